// File: doc/BRIEF.md
# Escape-Aware Virtual Channel Selector for a Mesh Output Port

This block sits at one output port of a 2D mesh router whose ports each carry eight virtual channels. Channel 0 downstream is the escape channel: flits in it must follow a west-first, turn-restricted path, whose dependence graph has no cycles. Channels 1 to 7 are adaptive channels that may follow any minimal route, and so may form dependence cycles. When a head flit has been routed to this port, the selector looks at the destination offset, the chosen output port and the free status of the downstream channels. It then names the one downstream channel to request.

Adaptive channels are always preferred. A round-robin pointer spreads the adaptive traffic fairly over channels 1 to 7. The escape channel is requested only when every adaptive channel is busy, and only when a flit placed in it at the next router could still go on west-first. If the flit still has to travel west, it must not enter the next router's escape channel through that router's north or south input. If nothing legal is free, no request is raised. The selection holds no state except the pointer, so it is worked out again in the next cycle. A flit may leave the escape channel at a later hop and return to adaptive channels; the selector makes this choice fresh at every hop.

Top module: `vcsel_mesh_port`

## Requirements
- R1: After reset the round-robin pointer is at channel 1. With `head_valid` high and all of `vc_free` set, `vc_id` is 1.
- R2: While `head_valid` is low, `vc_req` stays low, and a `vc_granted` pulse does not move the pointer.
- R3: Bit i of `vc_free` marks downstream channel i as free. Whenever any of bits 1 to 7 is set and `head_valid` is high, `vc_req` is high and `vc_id` is an adaptive channel (1 to 7) whose free bit is set.
- R4: Among free adaptive channels, `vc_id` is the first one found when scanning upward from the pointer and wrapping from 7 back to 1.
- R5: At a clock edge where `vc_req`, `vc_granted` are high and `vc_id` is adaptive, the pointer moves to `vc_id`+1, with 7 wrapping to 1. At every other edge, including escape grants, it holds.
- R6: `vc_id` is 0 (escape) only when no adaptive channel is free, bit 0 of `vc_free` is set and escape entry is legal. In that case `vc_req` is high.
- R7: Port codes are 0 local, 1 east, 2 west, 3 north, 4 south, and 5 to 7 invalid. The offsets `dst_dx` and `dst_dy` are signed: positive means east and north. Escape entry is illegal when the port is north or south and `dst_dx` is negative.
- R8: Escape entry also needs a productive hop: east needs `dst_dx`>0, west needs `dst_dx`<0, north needs `dst_dy`>0, south needs `dst_dy`<0, and local needs both offsets to be 0. Codes 5 to 7 are never legal.
- R9: If no adaptive channel is free and escape entry is illegal or channel 0 is busy, `vc_req` is low. The decision is recomputed from the inputs in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A routed head flit needs a downstream channel |
| dst_dx | input | OFS_W | Signed X offset to destination, east positive |
| dst_dy | input | OFS_W | Signed Y offset to destination, north positive |
| out_port | input | 3 | Output port chosen by route computation |
| vc_free | input | NUM_VC | Free flags of the downstream channels, bit i is channel i |
| vc_granted | input | 1 | The current request was accepted this cycle |
| vc_req | output | 1 | Request for a downstream channel |
| vc_id | output | VC_W | Channel requested |

## Verification
The sweep visits every port code with every offset pair, once with only the escape channel free and once with nothing free. A selector that missed the north/south trap would request channel 0 with a westward offset. One that skipped the productive-hop test would take the escape channel on a non-minimal hop. For each of the seven pointer positions, the adaptive sweep applies all 256 free patterns. This exposes wrong wrap points, a scan that starts one place off, and escape being picked while an adaptive channel is free. Sequences of grants check the wrap of the pointer from 7 to 1, and check that escape grants and grants without a head flit leave the pointer where it is.

// File: rtl/vcsel_pkg.sv
package vcsel_pkg;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  localparam int OFS_EXT_W = 16;
  typedef logic signed [OFS_EXT_W-1:0] ofs_t;

  // Hop must reduce distance in the direction it takes.
  function automatic logic hop_productive(logic [2:0] port, ofs_t dx, ofs_t dy);
    case (port)
      PORT_LOCAL: return (dx == 0) && (dy == 0);
      PORT_EAST:  return dx > 0;
      PORT_WEST:  return dx < 0;
      PORT_NORTH: return dy > 0;
      PORT_SOUTH: return dy < 0;
      default:    return 1'b0;
    endcase
  endfunction

  // Entering the next router vertically while west is still owed forces a
  // forbidden turn on a west-first escape path.
  function automatic logic vertical_west_trap(logic [2:0] port, ofs_t dx);
    return ((port == PORT_NORTH) || (port == PORT_SOUTH)) && (dx < 0);
  endfunction

  // Pointer successor inside the adaptive range 1..num_vc-1.
  function automatic int unsigned rr_successor(int unsigned cur, int unsigned num_vc);
    return (cur >= num_vc - 1) ? 1 : cur + 1;
  endfunction

endpackage

// File: rtl/vcsel_escape_gate.sv
module vcsel_escape_gate
  import vcsel_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic [2:0]             out_port,
  input  logic signed [OFS_W-1:0] dst_dx,
  input  logic signed [OFS_W-1:0] dst_dy,
  output logic                   hop_ok,
  output logic                   turn_trap
);

  ofs_t dx_ext;
  ofs_t dy_ext;

  always_comb begin
    dx_ext = {{(OFS_EXT_W-OFS_W){dst_dx[OFS_W-1]}}, dst_dx};
    dy_ext = {{(OFS_EXT_W-OFS_W){dst_dy[OFS_W-1]}}, dst_dy};
  end

  assign hop_ok    = hop_productive(out_port, dx_ext, dy_ext);
  assign turn_trap = vertical_west_trap(out_port, dx_ext);

endmodule

// File: rtl/vcsel_rr_pick.sv
module vcsel_rr_pick
  import vcsel_pkg::*;
#(
  parameter int NUM_VC = 8,
  localparam int VC_W  = $clog2(NUM_VC),
  localparam int N_ADP = NUM_VC - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] adapt_free,
  input  logic              advance,
  input  logic [VC_W-1:0]   adv_from,
  output logic              any_free,
  output logic [VC_W-1:0]   pick,
  output logic [VC_W-1:0]   ptr
);

  int idx;

  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    idx      = 0;
    for (int k = 0; k < N_ADP; k++) begin
      idx = ((int'(ptr) - 1 + k) % N_ADP) + 1;
      if (!any_free && adapt_free[idx]) begin
        any_free = 1'b1;
        pick     = VC_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= VC_W'(1);
    else if (advance)
      ptr <= VC_W'(rr_successor(int'(adv_from), NUM_VC));
  end

endmodule

// File: rtl/vcsel_mesh_port.sv
module vcsel_mesh_port
  import vcsel_pkg::*;
#(
  parameter int NUM_VC = 8,
  parameter int OFS_W  = 4,
  localparam int VC_W  = $clog2(NUM_VC),
  localparam int ESC_VC = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    head_valid,
  input  logic signed [OFS_W-1:0] dst_dx,
  input  logic signed [OFS_W-1:0] dst_dy,
  input  logic [2:0]              out_port,
  input  logic [NUM_VC-1:0]       vc_free,
  input  logic                    vc_granted,
  output logic                    vc_req,
  output logic [VC_W-1:0]         vc_id
);

  // Named internal events for the checker.
  logic              hop_ok;
  logic              turn_trap;
  logic              esc_legal;
  logic              esc_take;
  logic              any_adapt;
  logic [VC_W-1:0]   adapt_pick;
  logic [VC_W-1:0]   rr_ptr;
  logic [NUM_VC-1:0] adapt_mask;
  logic              rr_advance;

  always_comb begin
    adapt_mask         = vc_free;
    adapt_mask[ESC_VC] = 1'b0;
  end

  vcsel_escape_gate #(.OFS_W(OFS_W)) u_gate (
    .out_port  (out_port),
    .dst_dx    (dst_dx),
    .dst_dy    (dst_dy),
    .hop_ok    (hop_ok),
    .turn_trap (turn_trap)
  );

  assign esc_legal = hop_ok && !turn_trap;
  assign esc_take  = !any_adapt && vc_free[ESC_VC] && esc_legal;

  assign vc_req     = head_valid && (any_adapt || esc_take);
  assign vc_id      = any_adapt ? adapt_pick : VC_W'(ESC_VC);
  assign rr_advance = vc_req && vc_granted && any_adapt;

  vcsel_rr_pick #(.NUM_VC(NUM_VC)) u_rr (
    .clk        (clk),
    .rst_n      (rst_n),
    .adapt_free (adapt_mask),
    .advance    (rr_advance),
    .adv_from   (adapt_pick),
    .any_free   (any_adapt),
    .pick       (adapt_pick),
    .ptr        (rr_ptr)
  );

endmodule

// File: rtl/vcsel_mesh_port_chk.sv
module vcsel_mesh_port_chk #(
  parameter int NUM_VC = 8,
  parameter int OFS_W  = 4,
  localparam int VC_W  = $clog2(NUM_VC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              head_valid,
  input logic [OFS_W-1:0]  dst_dx,
  input logic [2:0]        out_port,
  input logic [NUM_VC-1:0] vc_free,
  input logic              vc_granted,
  input logic              vc_req,
  input logic [VC_W-1:0]   vc_id,
  input logic              hop_ok,
  input logic [VC_W-1:0]   rr_ptr
);

  logic adv_now;
  assign adv_now = vc_req && vc_granted && (vc_id != '0);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |-> !vc_req); // R2

  AST_REQ_ON_ADAPTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && (vc_free[NUM_VC-1:1] != '0)) |-> (vc_req && vc_id != '0)); // R3

  AST_SEL_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    vc_req |-> vc_free[vc_id]); // R3

  AST_ESC_LAST_RESORT: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_req && vc_id == '0) |-> (vc_free[NUM_VC-1:1] == '0)); // R6

  AST_ESC_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_req && vc_id == '0) |-> !(((out_port == 3'd3) || (out_port == 3'd4)) && dst_dx[OFS_W-1])); // R7

  AST_ESC_PRODUCTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_req && vc_id == '0) |-> hop_ok); // R8

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_now |=> (rr_ptr == (($past(vc_id) == VC_W'(NUM_VC-1)) ? VC_W'(1) : $past(vc_id) + VC_W'(1)))); // R5

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_now |=> $stable(rr_ptr)); // R5

endmodule

bind vcsel_mesh_port vcsel_mesh_port_chk #(.NUM_VC(NUM_VC), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .head_valid (head_valid),
  .dst_dx     (dst_dx),
  .out_port   (out_port),
  .vc_free    (vc_free),
  .vc_granted (vc_granted),
  .vc_req     (vc_req),
  .vc_id      (vc_id),
  .hop_ok     (hop_ok),
  .rr_ptr     (rr_ptr)
);

// File: tb/vcsel_mesh_port_test.sv
module vcsel_mesh_port_test;

  localparam int NUM_VC = 8;
  localparam int OFS_W  = 4;
  localparam int VC_W   = 3;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    head_valid = 1'b0;
  logic signed [OFS_W-1:0] dst_dx = '0;
  logic signed [OFS_W-1:0] dst_dy = '0;
  logic [2:0]              out_port = 3'd1;
  logic [NUM_VC-1:0]       vc_free = '0;
  logic                    vc_granted = 1'b0;
  logic                    vc_req;
  logic [VC_W-1:0]         vc_id;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vcsel_mesh_port #(.NUM_VC(NUM_VC), .OFS_W(OFS_W)) uut (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .dst_dx(dst_dx),
    .dst_dy(dst_dy), .out_port(out_port), .vc_free(vc_free),
    .vc_granted(vc_granted), .vc_req(vc_req), .vc_id(vc_id)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Escape legality, restated from R7/R8 by direction.
  function automatic bit exp_legal(int port, int dx, int dy);
    if (port == 0) return (dx == 0) && (dy == 0);
    if (port == 1) return dx > 0;
    if (port == 2) return dx < 0;
    if (port == 3) return (dy > 0) && (dx >= 0);
    if (port == 4) return (dy < 0) && (dx >= 0);
    return 1'b0;
  endfunction

  // First free adaptive channel scanning up from p, wrapping 7 -> 1.
  function automatic int exp_pick(int p, logic [7:0] f);
    for (int k = 0; k < 7; k++) begin
      int i;
      i = p + k;
      if (i > 7) i = i - 7;
      if (f[i]) return i;
    end
    return -1;
  endfunction

  task automatic set_ptr(input int p);
    int prev;
    prev = (p == 1) ? 7 : p - 1;
    @(negedge clk);
    head_valid = 1'b1; out_port = 3'd1; dst_dx = 4'sd1; dst_dy = 4'sd0;
    vc_free = 8'(1 << prev); vc_granted = 1'b1;
    @(negedge clk);
    vc_granted = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset pointer
    @(negedge clk);
    head_valid = 1'b1; vc_free = 8'hFF; out_port = 3'd1; dst_dx = 4'sd1;
    #1;
    check(vc_req == 1'b1, "R1 req", int'(vc_req), 1);
    check(vc_id == 3'd1, "R1 id", int'(vc_id), 1);

    // R2: no head flit, grant ignored
    @(negedge clk);
    head_valid = 1'b0; vc_granted = 1'b1;
    #1;
    check(vc_req == 1'b0, "R2 idle req", int'(vc_req), 0);
    @(negedge clk);
    vc_granted = 1'b0; head_valid = 1'b1;
    #1;
    check(vc_id == 3'd1, "R2 pointer held", int'(vc_id), 1);

    // R4/R5: grant sequence with all free, wraps 7 -> 1
    for (int g = 0; g < 10; g++) begin
      int e;
      e = (g % 7) + 1;
      @(negedge clk);
      vc_free = 8'hFF; vc_granted = 1'b1;
      #1;
      check(vc_id == 3'(e), "R5 grant sequence", int'(vc_id), e);
    end
    @(negedge clk);
    vc_granted = 1'b0;

    // R5: escape grant leaves pointer
    set_ptr(4);
    @(negedge clk);
    vc_free = 8'h01; vc_granted = 1'b1;
    #1;
    check(vc_req && vc_id == 3'd0, "R6 escape picked", int'(vc_id), 0);
    @(negedge clk);
    vc_granted = 1'b0; vc_free = 8'hFF;
    #1;
    check(vc_id == 3'd4, "R5 hold on escape grant", int'(vc_id), 4);

    // R3/R4/R6: all free patterns at every pointer
    for (int p = 1; p <= 7; p++) begin
      set_ptr(p);
      for (int f = 0; f < 256; f++) begin
        int e;
        @(negedge clk);
        vc_free = 8'(f);
        #1;
        e = exp_pick(p, 8'(f));
        if (e >= 0) begin
          check(vc_req == 1'b1, "R3 adaptive req", int'(vc_req), 1);
          check(int'(vc_id) == e, "R4 rr pick", int'(vc_id), e);
        end else begin
          check(vc_req == f[0], "R6 escape fallback req", int'(vc_req), f[0]);
          if (f[0]) check(vc_id == 3'd0, "R6 escape id", int'(vc_id), 0);
        end
      end
    end

    // R7/R8/R9: escape legality over all ports and offsets
    for (int port = 0; port < 8; port++) begin
      for (int dx = -8; dx < 8; dx++) begin
        for (int dy = -8; dy < 8; dy++) begin
          bit l;
          l = exp_legal(port, dx, dy);
          @(negedge clk);
          out_port = 3'(port); dst_dx = 4'(dx); dst_dy = 4'(dy); vc_free = 8'h01;
          #1;
          check(vc_req == l, (port >= 3 && port <= 4 && dx < 0) ? "R7 trap" : "R8 productive",
                int'(vc_req), int'(l));
          if (l) check(vc_id == 3'd0, "R6 escape id", int'(vc_id), 0);
          vc_free = 8'h00;
          #1;
          check(vc_req == 1'b0, "R9 nothing free", int'(vc_req), 0);
        end
      end
    end

    // R9: retried next cycle once adaptive frees up
    @(negedge clk);
    out_port = 3'd3; dst_dx = -4'sd2; dst_dy = 4'sd1; vc_free = 8'h01;
    #1;
    check(vc_req == 1'b0, "R9 withheld", int'(vc_req), 0);
    @(negedge clk);
    vc_free = 8'h21;
    #1;
    check(vc_req == 1'b1 && vc_id != 3'd0, "R9 retry", int'(vc_id), 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule